// File: doc/BRIEF.md
# Daisy-Chainable Serial Register Port

This block is the slave side of a three-wire serial command port (frame select, serial clock, data in) with a serial data output. It runs on a fast system clock and oversamples the three serial pins through synchronizer chains. It then decodes each 24-bit command into a one-cycle register write strobe that carries a 7-bit address and 16-bit data. Serial input bits are taken on falling serial-clock edges, most significant bit first. A command takes effect when frame select returns high.

The serial output has two uses. In chained mode it repeats the shifted input stream 24 serial clocks later, so that several devices can share one long frame. A read command names a register. In the next frame, which normally carries a no-op command, the port shifts that register's contents out. The register bank sits outside the block: it supplies the read data for the address the port presents. When the output is not needed, its enable drops so that an external driver can release the line to high impedance.

Top module: `sreg_port`

## Requirements
- R1: After reset, the write strobe, the serial output, its output enable and the read address are all 0.
- R2: A standalone frame of exactly 24 falling serial-clock edges is taken MSB first as {bit 23 = read flag, bits 22:16 = address, bits 15:0 = data}. With the read flag at 0 and a non-no-op address, the port raises the write strobe after frame select rises, showing that address and data.
- R3: In standalone mode, a frame with any falling-edge count other than 24 produces neither a write nor a read.
- R4: Address 0 is the no-op address, and a write command to it produces no write strobe.
- R5: A command with the read flag at 1 produces no write strobe and presents its address on the read address output once the frame ends.
- R6: In the frame after a read command, the output shifts the word {0, read address, read data}. Bit 23 is valid once frame select has fallen, and each following bit appears after each rising serial-clock edge, so the host samples bit 23-k before falling edge k+1.
- R7: In chained mode, the value driven after rising edge k is the bit taken in at falling edge k-23, so in a 48-clock frame the second 24 bits out are the first 24 bits in.
- R8: In chained mode, a frame of 24 or more clocks decodes its last 24 bits received.
- R9: The output enable is high at all times in chained mode, high during a readback frame, and low otherwise.
- R10: Each write strobe lasts exactly one system-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_en_i | input | 1 | 1 selects chained mode, 0 standalone |
| frame_n_i | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock, idle high |
| sdi_i | input | 1 | Serial data in |
| rd_data_i | input | 16 | Register contents for rd_addr_o |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 16 | Write data |
| rd_addr_o | output | 7 | Address of the latest read command |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = release) |

## Verification
The write path is exercised with randomly chosen addresses and data, which separates a correct MSB-first field split from a swapped or shifted one. Frames of 23 and 25 clocks check the exact-length rule. A no-op write shows that the address filter is present. A read followed by a no-op frame checks the readback word and its bit timing. A 48-clock chained frame, carrying two different commands, distinguishes "output delayed by 24 clocks" and "last 24 bits decoded" from any off-by-one in the delay or in the choice of word.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int WORD_W = 24;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 7;
    localparam int PIN_N  = 3;   // [0]=data in, [1]=serial clock, [2]=frame select

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic start;   // frame select fell
        logic stop;    // frame select rose
        logic fall;    // serial clock fell inside a frame
        logic rise;    // serial clock rose inside a frame
        logic bit_in;  // synchronized data in
    } pin_ev_t;

    function automatic cmd_t word_to_cmd(input logic [WORD_W-1:0] w);
        return cmd_t'(w);
    endfunction

    function automatic logic [WORD_W-1:0] readback_word(input logic [ADDR_W-1:0] a,
                                                        input logic [DATA_W-1:0] d);
        return {1'b0, a, d};
    endfunction
endpackage

// File: rtl/sreg_pin_front.sv
module sreg_pin_front
    import sreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_N-1:0] pins_i,
    output pin_ev_t          ev_o
);
    localparam logic [PIN_N-1:0] IDLE = 3'b110;

    logic [PIN_N-1:0] q, q_d;

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        logic [STAGES-1:0] st;
        always_ff @(posedge clk) begin
            if (rst) st <= {STAGES{IDLE[i]}};
            else     st <= {st[STAGES-2:0], pins_i[i]};
        end
        assign q[i] = st[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) q_d <= IDLE;
        else     q_d <= q;
    end

    always_comb begin
        ev_o.start  = q_d[2] & ~q[2];
        ev_o.stop   = ~q_d[2] & q[2];
        ev_o.fall   = q_d[1] & ~q[1] & ~q[2];
        ev_o.rise   = ~q_d[1] & q[1] & ~q[2];
        ev_o.bit_in = q[0];
    end
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
    import sreg_pkg::*;
#(
    parameter int                CNT_W    = 6,
    parameter logic [ADDR_W-1:0] NOP_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev_i,
    input  logic              chain_en_i,
    output logic              chain_bit_o,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    cmd_t              cmd;
    logic              word_ok;

    assign cmd         = word_to_cmd(shreg);
    assign word_ok     = chain_en_i ? (cnt >= CNT_WORD) : (cnt == CNT_WORD);
    assign chain_bit_o = shreg[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0; cnt <= '0; rd_req_o <= 1'b0; rd_addr_o <= '0;
            wr_stb_o <= 1'b0; wr_addr_o <= '0; wr_data_o <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            rd_req_o <= 1'b0;
            if (ev_i.start) begin
                cnt <= '0;
            end else if (ev_i.fall) begin
                shreg <= {shreg[WORD_W-2:0], ev_i.bit_in};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
            if (ev_i.stop && word_ok) begin
                if (cmd.rd) begin
                    rd_req_o  <= 1'b1;
                    rd_addr_o <= cmd.addr;
                end else if (cmd.addr != NOP_ADDR) begin
                    wr_stb_o  <= 1'b1;
                    wr_addr_o <= cmd.addr;
                    wr_data_o <= cmd.data;
                end
            end
        end
    end

    // R10
    stb_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);
    // R4
    stb_not_nop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> (wr_addr_o != NOP_ADDR));
    // R2
    stb_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> $past(ev_i.stop));
    // R3
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_i.fall && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev_i,
    input  logic              chain_en_i,
    input  logic              chain_bit_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    logic              rd_pend, rb_act;
    logic [WORD_W-1:0] rb_sh, rb_word;

    assign rb_word  = readback_word(rd_addr_i, rd_data_i);
    assign sdo_oe_o = chain_en_i | rb_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0; rb_act <= 1'b0; rb_sh <= '0; sdo_o <= 1'b0;
        end else begin
            if (ev_i.start) begin
                if (rd_pend) begin
                    rd_pend <= 1'b0;
                    rb_act  <= 1'b1;
                    sdo_o   <= rb_word[WORD_W-1];
                    rb_sh   <= rb_word << 1;
                end
            end else if (ev_i.rise) begin
                if (rb_act) begin
                    sdo_o <= rb_sh[WORD_W-1];
                    rb_sh <= rb_sh << 1;
                end else if (chain_en_i) begin
                    sdo_o <= chain_bit_i;
                end
            end else if (ev_i.stop) begin
                rb_act <= 1'b0;
                if (!chain_en_i) sdo_o <= 1'b0;
            end
            if (rd_req_i) rd_pend <= 1'b1;
        end
    end

    // R6
    sdo_moves_on_event_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo_o) |-> $past(ev_i.start || ev_i.rise || ev_i.stop));
    // R9
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ev_i.stop) && !chain_en_i) |-> !sdo_oe_o);
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                CNT_W       = 6,
    parameter logic [ADDR_W-1:0] NOP_ADDR    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chain_en_i,
    input  logic              frame_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    pin_ev_t ev;
    logic    chain_bit, rd_req;

    sreg_pin_front #(.STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .pins_i({frame_n_i, sclk_i, sdi_i}), .ev_o(ev)
    );

    sreg_rx #(.CNT_W(CNT_W), .NOP_ADDR(NOP_ADDR)) u_rx (
        .clk(clk), .rst(rst), .ev_i(ev), .chain_en_i(chain_en_i),
        .chain_bit_o(chain_bit), .rd_req_o(rd_req), .rd_addr_o(rd_addr_o),
        .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    sreg_tx u_tx (
        .clk(clk), .rst(rst), .ev_i(ev), .chain_en_i(chain_en_i),
        .chain_bit_i(chain_bit), .rd_req_i(rd_req), .rd_addr_i(rd_addr_o),
        .rd_data_i(rd_data_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
    );
endmodule

// File: tb/sreg_port_tb.sv
module sreg_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chain_en = 1'b0, frame_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic [15:0] rd_data;
    logic        wr_stb, sdo, sdo_oe;
    logic [6:0]  wr_addr, rd_addr;
    logic [15:0] wr_data;

    int n_chk = 0, n_fail = 0;
    int stb_cnt = 0, run_len = 0, max_run = 0;
    logic [6:0]  last_addr;
    logic [15:0] last_data;
    logic [63:0] capv;
    logic        oe_mid;
    bit          done = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] bank(input logic [6:0] a);
        return {a, a ^ 7'h55, 2'b10};
    endfunction
    function automatic logic [23:0] mk(input logic r, input logic [6:0] a, input logic [15:0] d);
        return {r, a, d};
    endfunction

    assign rd_data = bank(rd_addr);

    sreg_port u_dut (
        .clk(clk), .rst(rst), .chain_en_i(chain_en), .frame_n_i(frame_n),
        .sclk_i(sclk), .sdi_i(sdi), .rd_data_i(rd_data),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    always @(posedge clk) begin
        if (!rst && wr_stb) begin
            stb_cnt   <= stb_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
            run_len   <= run_len + 1;
            if (run_len + 1 > max_run) max_run <= run_len + 1;
        end else begin
            run_len <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        capv = '0;
        oe_mid = 1'b0;
        frame_n = 1'b0;
        ticks(8);
        for (int j = 0; j < n; j++) begin
            capv[j] = sdo;
            sdi = bits[n-1-j];
            ticks(2);
            sclk = 1'b0;
            ticks(6);
            sclk = 1'b1;
            ticks(6);
            if (j == n / 2) oe_mid = sdo_oe;
        end
        frame_n = 1'b1;
        ticks(14);
    endtask

    function automatic logic [23:0] cap_word(input int first);
        logic [23:0] w;
        for (int k = 0; k < 24; k++) w[23-k] = capv[first+k];
        return w;
    endfunction

    initial begin
        int base;
        logic [23:0] w, exp_rb;
        void'($urandom(32'd20240607));
        ticks(4);
        rst = 1'b0;
        ticks(4);
        // R1 reset state
        check(wr_stb == 0 && sdo == 0 && sdo_oe == 0, "R1", {wr_stb, sdo, sdo_oe}, 0);
        check(rd_addr == 0, "R1", rd_addr, 0);

        // R2 directed write
        base = stb_cnt;
        send({40'd0, mk(1'b0, 7'h12, 16'hBEEF)}, 24);
        check(stb_cnt == base + 1, "R2", stb_cnt - base, 1);
        check(last_addr == 7'h12 && last_data == 16'hBEEF, "R2", {last_addr, last_data}, {7'h12, 16'hBEEF});

        // R2 random writes
        for (int i = 0; i < 16; i++) begin
            logic [6:0]  a;
            logic [15:0] d;
            a = 7'($urandom_range(1, 127));
            d = 16'($urandom);
            base = stb_cnt;
            send({40'd0, mk(1'b0, a, d)}, 24);
            check(stb_cnt == base + 1 && last_addr == a && last_data == d, "R2",
                  {last_addr, last_data}, {a, d});
        end
        // R10 strobe width
        check(max_run == 1, "R10", max_run, 1);

        // R3 short and long frames
        base = stb_cnt;
        send({40'd0, mk(1'b0, 7'h33, 16'h1234)} >> 1, 23);
        check(stb_cnt == base, "R3", stb_cnt - base, 0);
        send({39'd0, mk(1'b0, 7'h33, 16'h1234), 1'b1}, 25);
        check(stb_cnt == base, "R3", stb_cnt - base, 0);
        send({39'd0, mk(1'b1, 7'h44, 16'h0), 1'b0}, 25);
        check(rd_addr == 0, "R3", rd_addr, 0);

        // R4 no-op write
        send({40'd0, mk(1'b0, 7'h00, 16'hAAAA)}, 24);
        check(stb_cnt == base, "R4", stb_cnt - base, 0);

        // R5 read request
        send({40'd0, mk(1'b1, 7'h2A, 16'h0)}, 24);
        check(stb_cnt == base, "R5", stb_cnt - base, 0);
        check(rd_addr == 7'h2A, "R5", rd_addr, 7'h2A);
        check(sdo_oe == 0, "R9", sdo_oe, 0);

        // R6 readback frame with no-op command
        exp_rb = {1'b0, 7'h2A, bank(7'h2A)};
        send({40'd0, mk(1'b0, 7'h00, 16'h0)}, 24);
        w = cap_word(0);
        check(w == exp_rb, "R6", w, exp_rb);
        check(oe_mid == 1, "R9", oe_mid, 1);
        check(sdo_oe == 0, "R9", sdo_oe, 0);
        check(stb_cnt == base, "R4", stb_cnt - base, 0);

        // R7 R8 chained frame of two commands
        chain_en = 1'b1;
        ticks(4);
        check(sdo_oe == 1, "R9", sdo_oe, 1);
        begin
            logic [23:0] wa, wb;
            wa = mk(1'b0, 7'h05, 16'hC3A5);
            wb = mk(1'b0, 7'h09, 16'h5A0F);
            base = stb_cnt;
            send({16'd0, wa, wb}, 48);
            w = cap_word(24);
            check(w == wa, "R7", w, wa);
            check(stb_cnt == base + 1 && last_addr == 7'h09 && last_data == 16'h5A0F, "R8",
                  {last_addr, last_data}, {7'h09, 16'h5A0F});
            check(sdo_oe == 1, "R9", sdo_oe, 1);
        end
        chain_en = 1'b0;
        ticks(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule